// File: doc/BRIEF.md
# Interrupt status and mask unit

This block gathers seven event sources into one interrupt status register and raises a single interrupt line. The sources are packet received, packet transmitted, receive error, transmit error, ring overwrite, tally-counter overflow and remote transfer complete. Datapath blocks signal most events as single-cycle pulses. The counter-overflow event is derived from the most significant bits of the network tally counters. A mask register chooses which status bits reach the interrupt output. The host clears status bits by writing ones to them.

The top bit of the status register is a read-only reset indicator with its own rules. A stop command arms a pending stop. The indicator sets once no frame is in flight. It also sets on a ring overwrite. It clears on a start command, or when the host removes a packet from the receive ring. The host reads both registers through a small register port with a one-bit address.

Top module: `isr_unit`

## Requirements
- R1: After synchronous reset the status register reads 0x80, the mask reads 0x00 and `irq_o` is low.
- R2: A pulse on an event input sets its status bit, readable one clock later: `evt_rx_ok` sets bit 0, `evt_tx_ok` bit 1, `evt_rx_err` bit 2, `evt_tx_err` bit 3, `evt_overwrite` bit 4, `evt_dma_done` bit 6.
- R3: Status bit 5 sets one clock after any bit of `tally_msb` goes from 0 to 1. A bit that stays high does not set bit 5 again after it has been cleared.
- R4: A host write to address 0 clears every status bit in 0..6 whose write-data bit is 1 and leaves the others unchanged. Bit 7 is never changed by a host write.
- R5: When an event and a host clear hit the same status bit in the same cycle, the bit is set afterwards.
- R6: A host write to address 1 loads mask bits 0..6 from write-data bits 0..6. Mask bit 7 always reads 0.
- R7: `irq_o` is a registered level equal to the OR over bits 0..6 of (status AND mask). It changes in the same clock as the status and mask values it depends on. Status bit 7 never raises it.
- R8: `cmd_stop` arms a pending stop. Status bit 7 sets at the first later clock edge at which `frame_busy` is low. While `frame_busy` stays high, bit 7 stays clear.
- R9: `evt_overwrite` sets status bit 7 as well as bit 4.
- R10: Status bit 7 clears one clock after `cmd_start` or `ring_freed`. `cmd_start` also cancels a pending stop. An overwrite or stop entry in the same cycle as `ring_freed` keeps bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | 1 | Host register select: 0 status, 1 mask |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data of the selected register |
| evt_rx_ok | input | 1 | Pulse: frame received without error |
| evt_tx_ok | input | 1 | Pulse: frame sent without error |
| evt_rx_err | input | 1 | Pulse: frame received with error |
| evt_tx_err | input | 1 | Pulse: transmit failed |
| evt_overwrite | input | 1 | Pulse: receive ring overrun |
| evt_dma_done | input | 1 | Pulse: remote transfer finished |
| tally_msb | input | TALLY_N | Most significant bits of the tally counters |
| cmd_stop | input | 1 | Pulse: stop command |
| cmd_start | input | 1 | Pulse: start command |
| frame_busy | input | 1 | Level: a frame is in flight |
| ring_freed | input | 1 | Pulse: host removed a packet from the ring |
| irq_o | output | 1 | Interrupt request level |

## Verification
Two things can land in one cycle: an event that sets a status bit and a host write-one that clears the same bit. The bench drives the pulse together with a clear-all write, once for every bit. Bit 5 gets the same treatment through a tally rising edge. The other bits must clear while the struck bit stays set. The reset indicator meets a similar collision, where an overwrite or a stop entry coincides with a start or ring-freed pulse. The set source must win there, except that start suppresses a pending stop.

// File: rtl/isr_pkg.sv
package isr_pkg;

    localparam int SRC_N   = 7;
    localparam int REG_W   = 8;
    localparam int B_RX_OK = 0;
    localparam int B_TX_OK = 1;
    localparam int B_RX_ER = 2;
    localparam int B_TX_ER = 3;
    localparam int B_OVW   = 4;
    localparam int B_CNT   = 5;
    localparam int B_DMA   = 6;
    localparam int B_RSTF  = 7;

    typedef enum logic {
        ADDR_STATUS = 1'b0,
        ADDR_MASK   = 1'b1
    } isr_addr_e;

    typedef struct packed {
        logic dma_done;
        logic cnt_ovf;
        logic overwrite;
        logic tx_err;
        logic rx_err;
        logic tx_ok;
        logic rx_ok;
    } isr_evt_t;

    function automatic logic w1c_bit(input logic old_v, input logic set_v,
                                     input logic clr_v);
        return set_v | (old_v & ~clr_v);
    endfunction

endpackage

// File: rtl/isr_rise_detect.sv
module isr_rise_detect #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic         any_rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign any_rise = |(lvl & ~prev_q);
endmodule

// File: rtl/isr_status_bits.sv
module isr_status_bits
    import isr_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] nxt_o,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb nxt_o[i] = w1c_bit(q_o[i], set_i[i], clr_i[i]);

        always_ff @(posedge clk) begin
            if (rst) q_o[i] <= 1'b0;
            else     q_o[i] <= nxt_o[i];
        end
    end
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] nxt_o,
    output logic [N-1:0] q_o
);
    assign nxt_o = we ? wdata : q_o;

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= nxt_o;
    end
endmodule

// File: rtl/isr_reset_tracker.sv
module isr_reset_tracker (
    input  logic clk,
    input  logic rst,
    input  logic cmd_stop,
    input  logic cmd_start,
    input  logic frame_busy,
    input  logic overwrite,
    input  logic ring_freed,
    output logic flag_q
);
    logic pend_q;
    logic enter;

    // a pending stop takes effect at the first idle edge, unless a start arrives
    assign enter = pend_q & ~frame_busy & ~cmd_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            flag_q <= 1'b1;
        end else begin
            if (cmd_start)    pend_q <= 1'b0;
            else if (cmd_stop) pend_q <= 1'b1;
            else if (enter)   pend_q <= 1'b0;

            if (enter || overwrite)          flag_q <= 1'b1;
            else if (cmd_start || ring_freed) flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/isr_unit.sv
module isr_unit
    import isr_pkg::*;
#(
    parameter int TALLY_N = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hst_we,
    input  logic               hst_addr,
    input  logic [7:0]         hst_wdata,
    output logic [7:0]         hst_rdata,
    input  logic               evt_rx_ok,
    input  logic               evt_tx_ok,
    input  logic               evt_rx_err,
    input  logic               evt_tx_err,
    input  logic               evt_overwrite,
    input  logic               evt_dma_done,
    input  logic [TALLY_N-1:0] tally_msb,
    input  logic               cmd_stop,
    input  logic               cmd_start,
    input  logic               frame_busy,
    input  logic               ring_freed,
    output logic               irq_o
);
    isr_evt_t         ev;
    logic             tally_rise;
    logic [SRC_N-1:0] clr_vec;
    logic [SRC_N-1:0] sts_nxt, sts_bits;
    logic [SRC_N-1:0] msk_nxt, msk_bits;
    logic             msk_we;
    logic             rst_flag;
    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] msk_q;

    isr_rise_detect #(.W(TALLY_N)) u_rise (
        .clk(clk), .rst(rst), .lvl(tally_msb), .any_rise(tally_rise)
    );

    always_comb begin
        ev.rx_ok     = evt_rx_ok;
        ev.tx_ok     = evt_tx_ok;
        ev.rx_err    = evt_rx_err;
        ev.tx_err    = evt_tx_err;
        ev.overwrite = evt_overwrite;
        ev.cnt_ovf   = tally_rise;
        ev.dma_done  = evt_dma_done;
    end

    assign clr_vec = (hst_we && hst_addr == ADDR_STATUS) ? hst_wdata[SRC_N-1:0] : '0;
    assign msk_we  = hst_we && hst_addr == ADDR_MASK;

    isr_status_bits #(.N(SRC_N)) u_sts (
        .clk(clk), .rst(rst), .set_i(ev), .clr_i(clr_vec),
        .nxt_o(sts_nxt), .q_o(sts_bits)
    );

    isr_mask_reg #(.N(SRC_N)) u_msk (
        .clk(clk), .rst(rst), .we(msk_we), .wdata(hst_wdata[SRC_N-1:0]),
        .nxt_o(msk_nxt), .q_o(msk_bits)
    );

    isr_reset_tracker u_rtrk (
        .clk(clk), .rst(rst), .cmd_stop(cmd_stop), .cmd_start(cmd_start),
        .frame_busy(frame_busy), .overwrite(evt_overwrite),
        .ring_freed(ring_freed), .flag_q(rst_flag)
    );

    // output register fed from next-state values so it lines up with status
    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |(sts_nxt & msk_nxt);
    end

    assign sts_q     = {rst_flag, sts_bits};
    assign msk_q     = {1'b0, msk_bits};
    assign hst_rdata = (hst_addr == ADDR_MASK) ? msk_q : sts_q;
endmodule

// File: rtl/isr_unit_chk.sv
module isr_unit_chk #(
    parameter int TALLY_N = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               hst_we,
    input logic               hst_addr,
    input logic [7:0]         hst_wdata,
    input logic               evt_rx_ok,
    input logic               evt_tx_ok,
    input logic               evt_rx_err,
    input logic               evt_tx_err,
    input logic               evt_overwrite,
    input logic               evt_dma_done,
    input logic [TALLY_N-1:0] tally_msb,
    input logic               cmd_start,
    input logic               frame_busy,
    input logic [7:0]         sts,
    input logic [7:0]         msk,
    input logic               irq
);
    logic any_pulse;
    assign any_pulse = evt_rx_ok | evt_tx_ok | evt_rx_err | evt_tx_err |
                       evt_overwrite | evt_dma_done;

    p_evt_rx_r2: assert property (@(posedge clk) disable iff (rst)
        evt_rx_ok |=> sts[0]);

    p_tally_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tally_msb[0]) |=> sts[5]);

    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (hst_we && !hst_addr && !any_pulse)
        |=> ((sts[6:0] & $past(hst_wdata[6:0]) & 7'h5F) == 7'h00));

    p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (evt_dma_done && hst_we && !hst_addr) |=> sts[6]);

    p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
        irq == |(sts[6:0] & msk[6:0]));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_busy && !sts[7] && !evt_overwrite) |=> !sts[7]);

    p_ovw_sets_r9: assert property (@(posedge clk) disable iff (rst)
        evt_overwrite |=> (sts[7] && sts[4]));

    p_start_clr_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !evt_overwrite) |=> !sts[7]);
endmodule

bind isr_unit isr_unit_chk #(.TALLY_N(TALLY_N)) u_chk (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .evt_rx_ok(evt_rx_ok), .evt_tx_ok(evt_tx_ok),
    .evt_rx_err(evt_rx_err), .evt_tx_err(evt_tx_err),
    .evt_overwrite(evt_overwrite), .evt_dma_done(evt_dma_done),
    .tally_msb(tally_msb), .cmd_start(cmd_start), .frame_busy(frame_busy),
    .sts(sts_q), .msk(msk_q), .irq(irq_o)
);

// File: tb/test_isr_unit.sv
module test_isr_unit;
    localparam int TN = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          hst_we, hst_addr;
    logic [7:0]    hst_wdata, hst_rdata;
    logic          evt_rx_ok, evt_tx_ok, evt_rx_err, evt_tx_err;
    logic          evt_overwrite, evt_dma_done;
    logic [TN-1:0] tally_msb;
    logic          cmd_stop, cmd_start, frame_busy, ring_freed;
    logic          irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [6:0]    m_sts, m_msk;
    logic          m_r7, m_pend, m_irq;
    logic [TN-1:0] m_tprev;

    always #10 clk = ~clk;

    isr_unit #(.TALLY_N(TN)) i_isr_unit (
        .clk(clk), .rst(rst), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .evt_rx_ok(evt_rx_ok), .evt_tx_ok(evt_tx_ok),
        .evt_rx_err(evt_rx_err), .evt_tx_err(evt_tx_err),
        .evt_overwrite(evt_overwrite), .evt_dma_done(evt_dma_done),
        .tally_msb(tally_msb), .cmd_stop(cmd_stop), .cmd_start(cmd_start),
        .frame_busy(frame_busy), .ring_freed(ring_freed), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic verify(input string tag);
        hst_addr = 1'b0; #1;
        chk(tag, "status", hst_rdata, {m_r7, m_sts});
        hst_addr = 1'b1; #1;
        chk(tag, "mask", hst_rdata, {1'b0, m_msk});
        chk(tag, "irq", {7'h0, irq_o}, {7'h0, m_irq});
    endtask

    // ev bits: 0 rx_ok, 1 tx_ok, 2 rx_err, 3 tx_err, 4 overwrite, 6 dma_done
    task automatic step(input string tag, input logic [6:0] ev,
                        input logic [TN-1:0] tl, input logic we,
                        input logic ad, input logic [7:0] wd,
                        input logic stp, input logic sta,
                        input logic busy, input logic fr);
        logic [6:0] set_v, clr_v, nsts, nmsk;
        logic       entry, npend, nr7;
        evt_rx_ok = ev[0]; evt_tx_ok = ev[1]; evt_rx_err = ev[2];
        evt_tx_err = ev[3]; evt_overwrite = ev[4]; evt_dma_done = ev[6];
        tally_msb = tl; hst_we = we; hst_addr = ad; hst_wdata = wd;
        cmd_stop = stp; cmd_start = sta; frame_busy = busy; ring_freed = fr;
        set_v = {ev[6], |(tl & ~m_tprev), ev[4:0]};
        clr_v = (we && !ad) ? wd[6:0] : 7'h0;
        nsts  = set_v | (m_sts & ~clr_v);
        nmsk  = (we && ad) ? wd[6:0] : m_msk;
        entry = m_pend & ~busy & ~sta;
        npend = sta ? 1'b0 : (stp | (m_pend & ~entry));
        nr7   = (entry | ev[4]) ? 1'b1 : ((sta | fr) ? 1'b0 : m_r7);
        @(posedge clk);
        m_sts = nsts; m_msk = nmsk; m_pend = npend; m_r7 = nr7;
        m_tprev = tl; m_irq = |(nsts & nmsk);
        @(negedge clk);
        hst_we = 1'b0; evt_rx_ok = 1'b0; evt_tx_ok = 1'b0; evt_rx_err = 1'b0;
        evt_tx_err = 1'b0; evt_overwrite = 1'b0; evt_dma_done = 1'b0;
        cmd_stop = 1'b0; cmd_start = 1'b0; ring_freed = 1'b0;
        verify(tag);
    endtask

    task automatic idle(input string tag, input logic busy);
        step(tag, 7'h0, '0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0, busy, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; hst_we = 0; hst_addr = 0; hst_wdata = 0;
        evt_rx_ok = 0; evt_tx_ok = 0; evt_rx_err = 0; evt_tx_err = 0;
        evt_overwrite = 0; evt_dma_done = 0; tally_msb = '0;
        cmd_stop = 0; cmd_start = 0; frame_busy = 0; ring_freed = 0;
        m_sts = 0; m_msk = 0; m_r7 = 1; m_pend = 0; m_irq = 0; m_tprev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        verify("R1");

        step("R10", 7'h0, '0, 0, 0, 8'h0, 0, 1, 0, 0);

        // each pulse source alone, then clear all
        for (int i = 0; i < 7; i++) begin
            if (i == 5) continue;
            step("R2", 7'(1 << i), '0, 0, 0, 8'h0, 0, 0, 0, 0);
            step("R4", 7'h0, '0, 1, 0, 8'hFF, 0, 0, 0, 0);
            step("R10", 7'h0, '0, 0, 0, 8'h0, 0, 0, 0, 1);
        end

        // tally rising edges
        for (int t = 1; t < 8; t++) begin
            step("R3", 7'h0, TN'(t), 0, 0, 8'h0, 0, 0, 0, 0);
            step("R3", 7'h0, TN'(t), 1, 0, 8'h20, 0, 0, 0, 0);
            idle("R3", 1'b0);
            step("R3", 7'h0, '0, 0, 0, 8'h0, 0, 0, 0, 0);
        end

        // every clear pattern against a full status
        for (int w = 0; w < 128; w++) begin
            step("R4", 7'h5F, 3'b001, 0, 0, 8'h0, 0, 0, 0, 0);
            step("R4", 7'h0, 3'b001, 1, 0, {w[0], 7'(w)}, 0, 0, 0, 0);
            step("R4", 7'h0, '0, 0, 0, 8'h0, 0, 0, 0, 0);
        end

        // event against clear of the same bit
        for (int i = 0; i < 7; i++) begin
            step("R5", 7'h7F & ~7'h20, 3'b000, 0, 0, 8'h0, 0, 0, 0, 0);
            if (i == 5)
                step("R5", 7'h0, 3'b100, 1, 0, 8'h7F, 0, 0, 0, 0);
            else
                step("R5", 7'(1 << i), '0, 1, 0, 8'h7F, 0, 0, 0, 0);
            step("R5", 7'h0, '0, 1, 0, 8'h7F, 0, 0, 0, 0);
        end

        // mask sweep against two status patterns
        step("R7", 7'h0, '0, 1, 0, 8'h7F, 0, 1, 0, 0);
        step("R7", 7'h0A, '0, 0, 0, 8'h0, 0, 0, 0, 0);
        for (int m = 0; m < 256; m++)
            step("R6", 7'h0, '0, 1, 1, 8'(m), 0, 0, 0, 0);
        step("R7", 7'h55, 3'b010, 0, 0, 8'h0, 0, 0, 0, 0);
        for (int m = 0; m < 256; m += 3)
            step("R7", 7'h0, 3'b010, 1, 1, 8'(m), 0, 0, 0, 0);
        // only the reset indicator set, full mask: no interrupt
        step("R7", 7'h0, '0, 1, 0, 8'h7F, 0, 0, 0, 0);
        step("R7", 7'h0, '0, 1, 1, 8'hFF, 1, 0, 0, 0);
        idle("R7", 1'b0);
        step("R7", 7'h0, '0, 0, 0, 8'h0, 0, 1, 0, 0);

        // stop waits for the frame to finish
        step("R8", 7'h0, '0, 0, 0, 8'h0, 1, 0, 1, 0);
        for (int k = 0; k < 4; k++) idle("R8", 1'b1);
        idle("R8", 1'b0);
        idle("R8", 1'b0);
        // start cancels a pending stop
        step("R10", 7'h0, '0, 0, 0, 8'h0, 0, 1, 1, 0);
        step("R10", 7'h0, '0, 0, 0, 8'h0, 1, 0, 1, 0);
        step("R10", 7'h0, '0, 0, 0, 8'h0, 0, 1, 1, 0);
        idle("R10", 1'b0);
        idle("R10", 1'b0);
        // start in the same cycle a stop would enter
        step("R10", 7'h0, '0, 0, 0, 8'h0, 1, 0, 1, 0);
        step("R10", 7'h0, '0, 0, 0, 8'h0, 0, 1, 0, 0);
        idle("R10", 1'b0);
        // stop entry against ring_freed: entry wins
        step("R10", 7'h0, '0, 0, 0, 8'h0, 1, 0, 0, 0);
        step("R10", 7'h0, '0, 0, 0, 8'h0, 0, 0, 0, 1);
        step("R10", 7'h0, '0, 0, 0, 8'h0, 0, 1, 0, 0);
        // overwrite against clears
        step("R9", 7'h10, '0, 0, 0, 8'h0, 0, 0, 0, 1);
        step("R10", 7'h0, '0, 0, 0, 8'h0, 0, 0, 0, 1);
        step("R9", 7'h10, '0, 0, 0, 8'h0, 0, 1, 0, 0);
        step("R9", 7'h0, '0, 1, 0, 8'hFF, 0, 0, 0, 0);
        step("R10", 7'h0, '0, 0, 0, 8'h0, 0, 1, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule